// File: doc/BRIEF.md
# Dual-Modulus Prescaler Feedback Divider

This block divides a fast input clock by a programmable ratio N = B·P + A. It does not use one wide binary counter. A small prescaler divides by either P+1 or P. A swallow counter holds the prescaler at P+1 for the first A prescaler periods of every output cycle. A main counter then counts B prescaler periods in total and marks the end of the output cycle. The output is a pulse one input cycle wide, once every N input cycles. The block sits in the feedback path of a frequency synthesizer loop, where the pulse goes to the phase comparator.

The control side drives A, B and a 2-bit prescaler mode select. The divider samples these inputs only at an output-cycle boundary, so a write never shortens or stretches a cycle that is already running. A setting with B below 3 or with A greater than B is reported on a flag and is never applied. The divider keeps running with the settings it last accepted. A synchronous reset restarts the cycle with the inputs present at reset if they are legal, and with a fixed default otherwise.

Top module: `dmod_fb_div`

## Requirements
- R1: With legal settings held, consecutive rising edges of `div_pulse` are exactly B·P + A input cycles apart, and `div_pulse` is high for exactly one cycle.
- R2: The mode select picks P as follows: 0 gives 8 (8/9), 1 gives 16 (16/17), 2 gives 32 (32/33), 3 gives 64 (64/65).
- R3: The boundary settings give the expected ratios: A = 0 gives N = B·P, and A = B gives N = B·(P+1), the prescaler then staying at P+1 for the whole cycle.
- R4: After a reset, the first `div_pulse` appears N cycles after the last clock edge at which `rst` is high. N comes from the inputs present at that edge if they are legal, and from the default A = 0, B = 16, mode 0 (N = 128) if they are not.
- R5: At the edge after any clock edge with `rst` high, `div_pulse` is 0.
- R6: A setting is legal when B ≥ 3 and B ≥ A. After each clock edge `cfg_bad` equals 1 exactly when the inputs present at that edge are illegal. An illegal setting present at a cycle boundary is not applied, and the next cycle keeps the previously accepted N.
- R7: A, B and mode are taken only at the edge that ends an output cycle (the edge that raises `div_pulse`). Changes between boundaries, including several changes, do not affect the cycle in progress. Only the values present at the boundary edge set the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_a | input | A_W (6) | Swallow count A |
| cfg_b | input | B_W (11) | Main count B |
| cfg_mode | input | 2 | Prescaler mode select, P = 8 << cfg_mode |
| div_pulse | output | 1 | One-cycle pulse at the end of every N-cycle output period |
| cfg_bad | output | 1 | High when the current A/B inputs are illegal |

## Verification
The hardest case to reach from the ports is a control write that lands in the middle of an output cycle, sometimes followed by a second write before the boundary. Only the last value present at the boundary edge may take effect, and only for the cycle after it. The stimulus changes the settings after a random delay into a running cycle, sometimes twice, and sometimes to an illegal value. The bench model takes the next cycle's ratio from whatever inputs were present at the edge that raised the pulse. It then compares every measured pulse spacing with B·P + A of the setting it holds in force. Directed cases add the minimum B, A equal to zero and to B, the largest counts, and a reset taken mid-cycle with illegal inputs.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

    // Prescaler mode select and derived moduli
    localparam int MODE_W      = 2;
    localparam int P_BASE_LOG2 = 3;                                  // smallest P = 8
    localparam int PC_W        = P_BASE_LOG2 + (2 ** MODE_W - 1) + 1; // holds largest P

    // Default counter widths
    localparam int A_W_DEF = 6;
    localparam int B_W_DEF = 11;

    // Legality and reset defaults
    localparam int B_MIN   = 3;
    localparam int DEF_B   = 16;

    typedef enum logic [MODE_W-1:0] {
        PS_8  = 2'd0,
        PS_16 = 2'd1,
        PS_32 = 2'd2,
        PS_64 = 2'd3
    } ps_mode_e;

    // Base modulus P for a mode
    function automatic logic [PC_W-1:0] p_of(ps_mode_e m);
        return PC_W'(32'd1 << (P_BASE_LOG2 + int'(m)));
    endfunction

endpackage

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
    import dmod_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ps_mode_e mode,
    input  logic     swallow,
    output logic     pre_end
);
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] last;

    // Divide by P+1 while swallowing, otherwise by P
    always_comb last = swallow ? p_of(mode) : p_of(mode) - 1'b1;
    assign pre_end = (pc == last);

    always_ff @(posedge clk) begin
        if (rst || pre_end) pc <= '0;
        else                pc <= pc + 1'b1;
    end

    // R2: the prescaler phase never passes the largest count of the P+1 modulus
    a_r2_pc_bound: assert property (@(posedge clk) disable iff (rst)
        pc <= p_of(mode));

endmodule

// File: rtl/dmod_swallow.sv
module dmod_swallow #(
    parameter int A_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [A_W-1:0] load_val,
    input  logic           pre_end,
    output logic           swallow
);
    logic [A_W-1:0] a_left;

    always_ff @(posedge clk) begin
        if (rst || load)                   a_left <= load_val;
        else if (pre_end && a_left != '0)  a_left <= a_left - 1'b1;
    end

    assign swallow = (a_left != '0);

    // R7: the swallow count only grows when a new cycle is loaded
    a_r7_swallow_monotone: assert property (@(posedge clk) disable iff (rst)
        !load |=> a_left <= $past(a_left));

endmodule

// File: rtl/dmod_main.sv
module dmod_main #(
    parameter int B_W = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_end,
    input  logic [B_W-1:0] b_val,
    output logic           term
);
    logic [B_W-1:0] b_cnt;

    // Last prescaler period of the output cycle
    assign term = pre_end && (b_cnt == b_val - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || term)  b_cnt <= '0;
        else if (pre_end) b_cnt <= b_cnt + 1'b1;
    end

    // R1: the main count stays below the programmed B
    a_r1_cnt_below_b: assert property (@(posedge clk) disable iff (rst)
        b_cnt < b_val);

endmodule

// File: rtl/dmod_fb_div.sv
module dmod_fb_div
    import dmod_pkg::*;
#(
    parameter int A_W = A_W_DEF,
    parameter int B_W = B_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [A_W-1:0]    cfg_a,
    input  logic [B_W-1:0]    cfg_b,
    input  logic [MODE_W-1:0] cfg_mode,
    output logic              div_pulse,
    output logic              cfg_bad
);
    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        ps_mode_e       mode;
    } div_set_t;

    div_set_t act;
    div_set_t req;
    div_set_t dflt;
    div_set_t nxt;
    logic     req_ok;
    logic     pre_end;
    logic     swallow;
    logic     term;

    always_comb begin
        req.a     = cfg_a;
        req.b     = cfg_b;
        req.mode  = ps_mode_e'(cfg_mode);
        dflt.a    = '0;
        dflt.b    = B_W'(DEF_B);
        dflt.mode = PS_8;
        req_ok    = (32'(cfg_b) >= B_MIN) && (32'(cfg_b) >= 32'(cfg_a));
        if (req_ok)   nxt = req;
        else if (rst) nxt = dflt;
        else          nxt = act;
    end

    // Settings change only at reset or a cycle boundary
    always_ff @(posedge clk) begin
        if (rst || term) act <= nxt;
        div_pulse <= rst ? 1'b0 : term;
        cfg_bad   <= !req_ok;
    end

    dmod_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .mode    (act.mode),
        .swallow (swallow),
        .pre_end (pre_end)
    );

    dmod_swallow #(.A_W(A_W)) u_swl (
        .clk      (clk),
        .rst      (rst),
        .load     (term),
        .load_val (nxt.a),
        .pre_end  (pre_end),
        .swallow  (swallow)
    );

    dmod_main #(.B_W(B_W)) u_main (
        .clk     (clk),
        .rst     (rst),
        .pre_end (pre_end),
        .b_val   (act.b),
        .term    (term)
    );

    // R6: an accepted setting is always legal
    a_r6_act_legal: assert property (@(posedge clk) disable iff (rst)
        (32'(act.b) >= B_MIN) && (act.b >= B_W'(act.a)));

    // R7: settings hold between cycle boundaries
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !term |=> $stable(act));

    // R1: the output pulse lasts one cycle
    a_r1_single: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R3: each cycle with A > 0 opens with the prescaler at P+1
    a_r3_swallow_start: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && act.a != '0) |-> swallow);

endmodule

// File: tb/sim_dmod_fb_div.sv
`timescale 1ns/1ps
module sim_dmod_fb_div;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_a = 6'd5;
    logic [10:0] cfg_b = 11'd10;
    logic [1:0]  cfg_mode = 2'd0;
    logic        div_pulse;
    logic        cfg_bad;

    int n_chk  = 0;
    int n_fail = 0;
    int npulse = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dmod_fb_div u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .cfg_mode  (cfg_mode),
        .div_pulse (div_pulse),
        .cfg_bad   (cfg_bad)
    );

    function automatic bit legal(int a, int b);
        return (b >= 3) && (b >= a);
    endfunction

    function automatic int ratio(int a, int b, int m);
        return b * (8 << m) + a;
    endfunction

    task automatic chk(bit good, string what, int got, int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    // Monitor: inputs change at posedge+2, so values seen at a negedge equal those at the next edge
    int cur_a = 0, cur_b = 16, cur_m = 0;
    int pa = 5, pb = 10, pm = 0;
    bit rst_prev = 1'b1;
    bit first = 1'b0;
    bit skipped = 1'b0;
    int cnt = 0;

    always @(negedge clk) begin
        if (!done) begin
            if (rst_prev) begin
                chk(div_pulse == 1'b0, "R5 pulse low after reset edge", int'(div_pulse), 0);
                cnt = 0;
                first = 1'b1;
                skipped = 1'b0;
                if (legal(pa, pb)) begin cur_a = pa; cur_b = pb; cur_m = pm; end
                else begin cur_a = 0; cur_b = 16; cur_m = 0; end
            end else begin
                cnt++;
                if (div_pulse) begin
                    string tag;
                    if (first) tag = "R4";
                    else if (skipped) tag = "R6";
                    else if (cur_a == 0 || cur_a == cur_b) tag = "R3";
                    else tag = "R1 R2 R7";
                    chk(cnt == ratio(cur_a, cur_b, cur_m),
                        $sformatf("%s period A=%0d B=%0d mode=%0d", tag, cur_a, cur_b, cur_m),
                        cnt, ratio(cur_a, cur_b, cur_m));
                    cnt = 0;
                    first = 1'b0;
                    npulse++;
                    if (legal(pa, pb)) begin
                        cur_a = pa; cur_b = pb; cur_m = pm; skipped = 1'b0;
                    end else begin
                        skipped = 1'b1;
                    end
                end
            end
            chk(cfg_bad == !legal(pa, pb),
                $sformatf("R6 flag A=%0d B=%0d", pa, pb), int'(cfg_bad), int'(!legal(pa, pb)));
            rst_prev = rst;
            pa = int'(cfg_a);
            pb = int'(cfg_b);
            pm = int'(cfg_mode);
        end
    end

    task automatic set_cfg(int a, int b, int m);
        @(posedge clk);
        #2;
        cfg_a = 6'(a);
        cfg_b = 11'(b);
        cfg_mode = 2'(m);
    endtask

    task automatic wait_pulses(int k);
        int tgt = npulse + k;
        while (npulse < tgt) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #2 rst = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        wait_pulses(3);                 // R4 with A=5 B=10 mode 0
        set_cfg(0, 3, 1);  wait_pulses(3);   // R3 A=0, minimum B
        set_cfg(7, 7, 2);  wait_pulses(3);   // R3 A=B
        set_cfg(1, 4, 3);  wait_pulses(3);   // R2 largest P
        set_cfg(0, 2, 0);  wait_pulses(3);   // R6 B below minimum
        set_cfg(9, 5, 1);  wait_pulses(2);   // R6 A above B
        set_cfg(63, 2047, 0); wait_pulses(2); // largest counts
        set_cfg(3, 3, 0);  wait_pulses(2);
        set_cfg(0, 0, 2);                   // illegal inputs during reset
        do_reset();                         // R4 default ratio
        wait_pulses(2);
        for (int i = 0; i < 40; i++) begin
            int b, a, m;
            wait_pulses(1);
            repeat ($urandom_range(15)) @(posedge clk);
            b = 3 + $urandom_range(27);
            a = $urandom_range(b);
            m = $urandom_range(3);
            if ($urandom_range(5) == 0) begin
                if ($urandom_range(1) == 0) b = $urandom_range(2);
                else a = (b < 63) ? b + 1 : 63;
                if (a > 63) a = 63;
            end
            set_cfg(a, b, m);
            if ($urandom_range(3) == 0) begin   // R7 second write before boundary
                repeat ($urandom_range(4)) @(posedge clk);
                b = 3 + $urandom_range(27);
                set_cfg($urandom_range(b), b, $urandom_range(3));
            end
            if (i == 20) do_reset();            // mid-cycle reset
        end
        wait_pulses(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d pulses", npulse, -1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule